// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a compact 32-bit processor that completes one instruction on every clock edge. The program counter selects a word from an instruction ROM that is fixed at elaboration through a parameter. Operands come from a 32-entry register file whose reads are asynchronous. The ALU combines them. A word-addressed data RAM serves loads and stores, and the result is written back at the next rising edge. Choosing the next PC is part of the same cycle. The candidates are the sequential address, a PC-relative branch target, a region-relative jump target, or a register value.

The core has no bus interface. Its only outputs are debug observation ports that carry the current PC, the register-file write port and the data-memory write port. A bench can follow execution instruction by instruction through them. Reset is synchronous and active high. While it is held, no architectural state is written.

Top module: `rc_core`

## Requirements
- R1: A synchronous reset sets the PC to 0x00400000 and zeroes all registers. While reset is high, dbg_rf_we and dbg_mem_we are 0. Reset taken in the middle of a run restarts execution at 0x00400000 on the next edge.
- R2: With no control transfer, the PC advances by 4 each clock. The instruction is the ROM word selected by PC bits above bit 1.
- R3: Register 0 always reads as zero. A write addressed to it appears on the write port but leaves the register at zero.
- R4: Register-register operations have opcode 0 in bits [31:26], rs in [25:21], rt in [20:16], rd in [15:11], shamt in [10:6] and the function code in [5:0]. Each writes rd. The function codes are: add 0x20, addu 0x21, sub 0x22 (rs minus rt), subu 0x23, and 0x24, or 0x25, xor 0x26, nor 0x27, signed set-less-than 0x2A, unsigned set-less-than 0x2B. The set-less-than forms write 1 or 0.
- R5: Shift operations shift rt and write rd. The amount comes from shamt for the fixed forms (left 0x00, logical right 0x02, arithmetic right 0x03) and from rs[4:0] for the variable forms (0x04, 0x06, 0x07). Arithmetic right fills with the sign bit.
- R6: Immediate operations use rs and the 16-bit field in [15:0], and write rt. The opcodes are: addi 0x08 and addiu 0x09, signed slti 0x0A and unsigned sltiu 0x0B, andi 0x0C, ori 0x0D, xori 0x0E, and lui 0x0F. The adds and compares sign-extend the immediate. The logic forms zero-extend it. lui places the immediate in the upper half with the lower half zero, so lui 0x1234 then ori 0x5678 yields 0x12345678.
- R7: Load word (0x23) writes rt with the data word at rs + sign-extended offset. Store word (0x2B) writes rt's value there and writes no register. Address bits [1:0] are ignored. dbg_mem_addr shows the full effective address.
- R8: A load in the cycle right after a store to the same word returns the stored value.
- R9: BEQ (0x04) is taken when rs equals rt and BNE (0x05) when they differ. The taken target is PC + 4 + (sign-extended offset shifted left 2). Otherwise the PC moves to PC + 4. Neither writes a register or memory.
- R10: J (0x02) sets the PC to {PC[31:28], instr[25:0], 2'b00} and writes nothing.
- R11: JR (opcode 0, function 0x08) sets the PC to the value of rs and writes nothing.
- R12: An unrecognised opcode or function code writes neither a register nor memory, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dbg_pc | output | 32 | Address of the instruction executing this cycle |
| dbg_rf_we | output | 1 | Register-file write happens at the coming edge |
| dbg_rf_waddr | output | 5 | Destination register index |
| dbg_rf_wdata | output | 32 | Value written to the destination register |
| dbg_mem_we | output | 1 | Data-memory write happens at the coming edge |
| dbg_mem_addr | output | 32 | Effective data address (loads and stores) |
| dbg_mem_wdata | output | 32 | Word being stored |

## Verification
Two activities can land on the same clock edge. One instruction's write-back, to a register or to the data RAM, commits at that edge. The next instruction reads the same location combinationally right after it. The program provokes this in three places: a store followed at once by a load of the same word, a register loaded by lui/ori and then consumed by JR in the following cycle, and a write aimed at register 0 followed by a read of it. Each case is judged on the debug ports. The loaded value, the PC the jump lands on, and the zero sum must match values worked out in advance from the requirements.

// File: rtl/rc_pkg.sv
package rc_pkg;

  localparam int unsigned XLEN = 32;
  localparam int unsigned REG_COUNT = 32;
  localparam int unsigned REG_AW = $clog2(REG_COUNT);

  // primary opcodes
  localparam logic [5:0] OP_REGOP = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_ADDIU = 6'h09;
  localparam logic [5:0] OP_SLTI  = 6'h0A;
  localparam logic [5:0] OP_SLTIU = 6'h0B;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_XORI  = 6'h0E;
  localparam logic [5:0] OP_LUI   = 6'h0F;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  // function codes for opcode 0
  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_SLLV = 6'h04;
  localparam logic [5:0] FN_SRLV = 6'h06;
  localparam logic [5:0] FN_SRAV = 6'h07;
  localparam logic [5:0] FN_JR   = 6'h08;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA, ALU_LUI
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    dst_rd;     // 1: rd is destination, 0: rt
    logic    use_imm;
    logic    imm_zero;   // zero-extend instead of sign-extend
    logic    shift_var;  // shift amount from rs[4:0]
    logic    mem_read;
    logic    mem_write;
    logic    br_eq;
    logic    br_ne;
    logic    jump;
    logic    jump_reg;
    logic    illegal;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [XLEN-1:0] ext_imm(input logic [15:0] imm, input logic zero_ext);
    return zero_ext ? {16'h0000, imm} : {{16{imm[15]}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] pc_seq,
                                                  input logic [15:0] off);
    return pc_seq + {{14{off[15]}}, off, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] pc,
                                                input logic [25:0] idx);
    return {pc[XLEN-1:28], idx, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op, input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b, input logic [4:0] sh);
    logic [XLEN-1:0] r;
    case (op)
      ALU_ADD:  r = a + b;
      ALU_SUB:  r = a - b;
      ALU_AND:  r = a & b;
      ALU_OR:   r = a | b;
      ALU_XOR:  r = a ^ b;
      ALU_NOR:  r = ~(a | b);
      ALU_SLT:  r = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLTU: r = {{(XLEN-1){1'b0}}, (a < b)};
      ALU_SLL:  r = b << sh;
      ALU_SRL:  r = b >> sh;
      ALU_SRA:  r = $unsigned($signed(b) >>> sh);
      ALU_LUI:  r = {b[15:0], 16'h0000};
      default:  r = a + b;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rc_decode.sv
module rc_decode
  import rc_pkg::*;
(
  input  logic [31:0] instr,
  output ctrl_t       ctrl
);

  logic [5:0] opcode;
  logic [5:0] funct;

  assign opcode = instr[31:26];
  assign funct  = instr[5:0];

  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    case (opcode)
      OP_REGOP: begin
        ctrl.reg_write = 1'b1;
        ctrl.dst_rd    = 1'b1;
        case (funct)
          FN_ADD, FN_ADDU: ctrl.alu_op = ALU_ADD;
          FN_SUB, FN_SUBU: ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_XOR:  ctrl.alu_op = ALU_XOR;
          FN_NOR:  ctrl.alu_op = ALU_NOR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          FN_SLTU: ctrl.alu_op = ALU_SLTU;
          FN_SLL:  ctrl.alu_op = ALU_SLL;
          FN_SRL:  ctrl.alu_op = ALU_SRL;
          FN_SRA:  ctrl.alu_op = ALU_SRA;
          FN_SLLV: begin ctrl.alu_op = ALU_SLL; ctrl.shift_var = 1'b1; end
          FN_SRLV: begin ctrl.alu_op = ALU_SRL; ctrl.shift_var = 1'b1; end
          FN_SRAV: begin ctrl.alu_op = ALU_SRA; ctrl.shift_var = 1'b1; end
          FN_JR: begin
            ctrl.reg_write = 1'b0;
            ctrl.jump_reg  = 1'b1;
          end
          default: begin
            ctrl.reg_write = 1'b0;
            ctrl.illegal   = 1'b1;
          end
        endcase
      end
      OP_ADDI, OP_ADDIU: begin
        ctrl.reg_write = 1'b1;
        ctrl.use_imm   = 1'b1;
      end
      OP_SLTI: begin
        ctrl.reg_write = 1'b1;
        ctrl.use_imm   = 1'b1;
        ctrl.alu_op    = ALU_SLT;
      end
      OP_SLTIU: begin
        ctrl.reg_write = 1'b1;
        ctrl.use_imm   = 1'b1;
        ctrl.alu_op    = ALU_SLTU;
      end
      OP_ANDI, OP_ORI, OP_XORI, OP_LUI: begin
        ctrl.reg_write = 1'b1;
        ctrl.use_imm   = 1'b1;
        ctrl.imm_zero  = 1'b1;
        case (opcode)
          OP_ANDI: ctrl.alu_op = ALU_AND;
          OP_ORI:  ctrl.alu_op = ALU_OR;
          OP_XORI: ctrl.alu_op = ALU_XOR;
          default: ctrl.alu_op = ALU_LUI;
        endcase
      end
      OP_LW: begin
        ctrl.reg_write = 1'b1;
        ctrl.use_imm   = 1'b1;
        ctrl.mem_read  = 1'b1;
      end
      OP_SW: begin
        ctrl.use_imm   = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl.br_eq  = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OP_BNE: begin
        ctrl.br_ne  = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OP_J: ctrl.jump = 1'b1;
      default: ctrl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/rc_alu.sv
module rc_alu
  import rc_pkg::*;
(
  input  alu_op_e          op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  input  logic [4:0]       shamt,
  output logic [XLEN-1:0]  y,
  output logic             zero
);

  assign y    = alu_eval(op, a, b, shamt);
  assign zero = (y == '0);

endmodule

// File: rtl/rc_regfile.sv
module rc_regfile #(
  parameter  int unsigned NREGS = 32,
  parameter  int unsigned DW    = 32,
  localparam int unsigned AW    = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd
);

  logic [DW-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

endmodule

// File: rtl/rc_dmem.sv
module rc_dmem #(
  parameter  int unsigned WORDS = 256,
  parameter  int unsigned DW    = 32,
  localparam int unsigned AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [31:0]   addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [WORDS];
  logic [AW-1:0] idx;
  logic          unused_addr_bits;

  assign idx = addr[AW+1:2];
  assign unused_addr_bits = ^{addr[31:AW+2], addr[1:0]};

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/rc_core.sv
module rc_core
  import rc_pkg::*;
#(
  parameter int unsigned IMEM_WORDS = 64,
  parameter int unsigned DMEM_WORDS = 256,
  parameter logic [31:0] RESET_PC   = 32'h0040_0000,
  parameter logic [31:0] IMEM_INIT [IMEM_WORDS] = '{default: 32'h0}
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] dbg_pc,
  output logic        dbg_rf_we,
  output logic [4:0]  dbg_rf_waddr,
  output logic [31:0] dbg_rf_wdata,
  output logic        dbg_mem_we,
  output logic [31:0] dbg_mem_addr,
  output logic [31:0] dbg_mem_wdata
);

  localparam int unsigned IAW = $clog2(IMEM_WORDS);

  logic [XLEN-1:0]   pc_q, pc_seq, pc_next;
  logic [31:0]       instr;
  ctrl_t             ctrl;
  logic [REG_AW-1:0] rs_idx, rt_idx, rd_idx, waddr;
  logic [XLEN-1:0]   rs_val, rt_val, imm_ext, alu_b, alu_y, mem_rdata, wb_data;
  logic [4:0]        shamt;
  logic              alu_zero;

  // named events for the checker
  logic ev_branch, ev_branch_taken, ev_jump, ev_jr, ev_store, ev_illegal;
  logic rf_we, mem_we;

  // fetch
  assign instr  = IMEM_INIT[pc_q[IAW+1:2]];
  assign pc_seq = pc_q + 32'd4;

  // decode
  rc_decode u_decode (
    .instr (instr),
    .ctrl  (ctrl)
  );

  assign rs_idx = instr[25:21];
  assign rt_idx = instr[20:16];
  assign rd_idx = instr[15:11];
  assign waddr  = ctrl.dst_rd ? rd_idx : rt_idx;

  rc_regfile #(.NREGS(REG_COUNT), .DW(XLEN)) u_regfile (
    .clk  (clk),
    .rst  (rst),
    .ra_a (rs_idx),
    .ra_b (rt_idx),
    .rd_a (rs_val),
    .rd_b (rt_val),
    .we   (rf_we),
    .wa   (waddr),
    .wd   (wb_data)
  );

  // execute
  assign imm_ext = ext_imm(instr[15:0], ctrl.imm_zero);
  assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;
  assign shamt   = ctrl.shift_var ? rs_val[4:0] : instr[10:6];

  rc_alu u_alu (
    .op    (ctrl.alu_op),
    .a     (rs_val),
    .b     (alu_b),
    .shamt (shamt),
    .y     (alu_y),
    .zero  (alu_zero)
  );

  // memory
  rc_dmem #(.WORDS(DMEM_WORDS), .DW(XLEN)) u_dmem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (alu_y),
    .wdata (rt_val),
    .rdata (mem_rdata)
  );

  // write-back
  assign wb_data = ctrl.mem_read ? mem_rdata : alu_y;
  assign rf_we   = ctrl.reg_write & ~rst;
  assign mem_we  = ctrl.mem_write & ~rst;

  // control transfer
  assign ev_branch       = ctrl.br_eq | ctrl.br_ne;
  assign ev_branch_taken = (ctrl.br_eq & alu_zero) | (ctrl.br_ne & ~alu_zero);
  assign ev_jump         = ctrl.jump;
  assign ev_jr           = ctrl.jump_reg;
  assign ev_store        = ctrl.mem_write;
  assign ev_illegal      = ctrl.illegal;

  always_comb begin
    if (ev_jr)                pc_next = rs_val;
    else if (ev_jump)         pc_next = jump_dest(pc_q, instr[25:0]);
    else if (ev_branch_taken) pc_next = branch_dest(pc_seq, instr[15:0]);
    else                      pc_next = pc_seq;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_next;
  end

  // debug observation
  assign dbg_pc        = pc_q;
  assign dbg_rf_we     = rf_we;
  assign dbg_rf_waddr  = waddr;
  assign dbg_rf_wdata  = wb_data;
  assign dbg_mem_we    = mem_we;
  assign dbg_mem_addr  = alu_y;
  assign dbg_mem_wdata = rt_val;

endmodule

// File: rtl/rc_core_checker.sv
module rc_core_checker #(
  parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [4:0]  rs_idx,
  input logic [31:0] rs_val,
  input logic        rf_we,
  input logic        mem_we,
  input logic        ev_branch,
  input logic        ev_taken,
  input logic        ev_jump,
  input logic        ev_jr,
  input logic        ev_store,
  input logic        ev_illegal
);

  a_r1_reset_pc: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pc == RESET_PC);

  a_r2_pc_advance: assert property (@(posedge clk) disable iff (rst)
    (!ev_taken && !ev_jump && !ev_jr) |=> pc == $past(pc) + 32'd4);

  a_r3_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (rs_idx == 5'd0) |-> rs_val == 32'd0);

  a_r7_store_no_reg: assert property (@(posedge clk) disable iff (rst)
    ev_store |-> !rf_we);

  a_r9_branch_quiet: assert property (@(posedge clk) disable iff (rst)
    ev_branch |-> (!rf_we && !mem_we));

  a_r9_branch_target: assert property (@(posedge clk) disable iff (rst)
    ev_taken |=> pc == $past(pc) + 32'd4 +
                 {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

  a_r10_jump_target: assert property (@(posedge clk) disable iff (rst)
    ev_jump |=> pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00});

  a_r11_jr_target: assert property (@(posedge clk) disable iff (rst)
    ev_jr |=> pc == $past(rs_val));

  a_r12_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    ev_illegal |-> (!rf_we && !mem_we));

  a_r2_one_redirect: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_taken, ev_jump, ev_jr}));

endmodule

bind rc_core rc_core_checker #(.RESET_PC(RESET_PC)) u_rc_core_checker (
  .clk        (clk),
  .rst        (rst),
  .pc         (pc_q),
  .instr      (instr),
  .rs_idx     (rs_idx),
  .rs_val     (rs_val),
  .rf_we      (rf_we),
  .mem_we     (mem_we),
  .ev_branch  (ev_branch),
  .ev_taken   (ev_branch_taken),
  .ev_jump    (ev_jump),
  .ev_jr      (ev_jr),
  .ev_store   (ev_store),
  .ev_illegal (ev_illegal)
);

// File: tb/test_rc_core.sv
module test_rc_core;

  localparam int unsigned NW = 64;
  localparam logic [31:0] BASE = 32'h0040_0000;
  typedef logic [31:0] img_t [NW];

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                        input int sh, input int fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(input int op, input int rs, input int rt,
                                        input logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction

  function automatic img_t make_prog();
    img_t p;
    for (int i = 0; i < NW; i++) p[i] = 32'h0;
    p[0]  = enc_i(8'h0F, 0, 1, 16'h1234);      // lui  $1
    p[1]  = enc_i(8'h0D, 1, 1, 16'h5678);      // ori  $1
    p[2]  = enc_i(8'h08, 0, 2, 16'hFFFD);      // addi $2 = -3
    p[3]  = enc_i(8'h08, 0, 3, 16'h0005);      // addi $3 = 5
    p[4]  = enc_r(2, 3, 4, 0, 8'h20);          // add
    p[5]  = enc_r(2, 3, 5, 0, 8'h22);          // sub
    p[6]  = enc_r(2, 3, 6, 0, 8'h2A);          // slt
    p[7]  = enc_r(2, 3, 7, 0, 8'h2B);          // sltu
    p[8]  = enc_r(0, 5, 8, 2, 8'h03);          // sra
    p[9]  = enc_r(0, 5, 9, 28, 8'h02);         // srl
    p[10] = enc_r(1, 0, 10, 0, 8'h27);         // nor
    p[11] = enc_i(8'h08, 3, 0, 16'd7);         // addi $0
    p[12] = enc_r(0, 3, 11, 0, 8'h20);         // add $11 = $0 + $3
    p[13] = enc_i(8'h2B, 3, 1, 16'd8);         // sw  $1, 8($3)  -> 13
    p[14] = enc_i(8'h23, 3, 12, 16'd10);       // lw  $12,10($3) -> 15
    p[15] = enc_i(8'h2B, 0, 10, 16'd0);        // sw  $10,0($0)
    p[16] = enc_i(8'h23, 0, 13, 16'd0);        // lw  $13,0($0)
    p[17] = enc_i(8'h04, 3, 11, 16'd2);        // beq taken -> 20
    p[18] = enc_i(8'h08, 0, 14, 16'd1);
    p[19] = enc_i(8'h08, 0, 14, 16'd2);
    p[20] = enc_i(8'h05, 3, 11, 16'd5);        // bne not taken
    p[21] = enc_i(8'h05, 2, 3, 16'd1);         // bne taken -> 23
    p[22] = enc_i(8'h08, 0, 14, 16'd3);
    p[23] = enc_i(8'h04, 2, 3, 16'd5);         // beq not taken
    p[24] = {6'h02, 26'h010001C};              // j 0x00400070
    p[25] = enc_i(8'h08, 0, 14, 16'd4);
    p[26] = enc_i(8'h08, 0, 14, 16'd4);
    p[27] = enc_i(8'h08, 0, 14, 16'd4);
    p[28] = enc_i(8'h0F, 0, 15, 16'h0040);     // lui $15
    p[29] = enc_i(8'h0D, 15, 15, 16'h0080);    // ori $15
    p[30] = enc_r(15, 0, 0, 0, 8'h08);         // jr $15
    p[31] = enc_i(8'h08, 0, 14, 16'd5);
    p[32] = enc_i(8'h0C, 2, 14, 16'hF0F0);     // andi
    p[33] = 32'hFC00_0000;                     // unrecognised opcode
    p[34] = enc_i(8'h04, 0, 0, 16'hFFFF);      // beq self loop
    return p;
  endfunction

  localparam img_t PROG = make_prog();

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dbg_pc, dbg_rf_wdata, dbg_mem_addr, dbg_mem_wdata;
  logic        dbg_rf_we, dbg_mem_we;
  logic [4:0]  dbg_rf_waddr;

  int tests_run = 0;
  int tests_failed = 0;

  always #5 clk = ~clk;

  rc_core #(.IMEM_WORDS(NW), .DMEM_WORDS(256), .RESET_PC(BASE), .IMEM_INIT(PROG)) i_rc_core (
    .clk           (clk),
    .rst           (rst),
    .dbg_pc        (dbg_pc),
    .dbg_rf_we     (dbg_rf_we),
    .dbg_rf_waddr  (dbg_rf_waddr),
    .dbg_rf_wdata  (dbg_rf_wdata),
    .dbg_mem_we    (dbg_mem_we),
    .dbg_mem_addr  (dbg_mem_addr),
    .dbg_mem_wdata (dbg_mem_wdata)
  );

  function automatic logic [31:0] pa(input int idx);
    return BASE + 32'(idx * 4);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // compare one executed instruction, then move to the next one
  task automatic step(input string req, input logic [31:0] e_pc, input logic e_rwe,
                      input logic [4:0] e_wa, input logic [31:0] e_wd, input logic e_mwe,
                      input logic [31:0] e_ma, input logic [31:0] e_md);
    chk(req, "pc", dbg_pc, e_pc);
    chk(req, "rf_we", 32'(dbg_rf_we), 32'(e_rwe));
    if (e_rwe) begin
      chk(req, "rf_waddr", 32'(dbg_rf_waddr), 32'(e_wa));
      chk(req, "rf_wdata", dbg_rf_wdata, e_wd);
    end
    chk(req, "mem_we", 32'(dbg_mem_we), 32'(e_mwe));
    if (e_mwe) begin
      chk(req, "mem_addr", dbg_mem_addr, e_ma);
      chk(req, "mem_wdata", dbg_mem_wdata, e_md);
    end
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input string req, input int idx, input int wa, input logic [31:0] wd);
    step(req, pa(idx), 1'b1, 5'(wa), wd, 1'b0, 32'h0, 32'h0);
  endtask

  task automatic quiet(input string req, input int idx);
    step(req, pa(idx), 1'b0, 5'd0, 32'h0, 1'b0, 32'h0, 32'h0);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1", "pc in reset", dbg_pc, BASE);
    chk("R1", "rf_we in reset", 32'(dbg_rf_we), 32'h0);
    chk("R1", "mem_we in reset", 32'(dbg_mem_we), 32'h0);
    rst = 1'b0;
    #1;
  endtask

  task automatic t_alu();
    wr("R6 lui", 0, 1, 32'h1234_0000);
    wr("R6 ori", 1, 1, 32'h1234_5678);
    wr("R6 addi sign", 2, 2, 32'hFFFF_FFFD);
    wr("R2 addi", 3, 3, 32'h0000_0005);
    wr("R4 add", 4, 4, 32'h0000_0002);
    wr("R4 sub", 5, 5, 32'hFFFF_FFF8);
    wr("R4 slt", 6, 6, 32'h0000_0001);
    wr("R4 sltu", 7, 7, 32'h0000_0000);
    wr("R5 sra", 8, 8, 32'hFFFF_FFFE);
    wr("R5 srl", 9, 9, 32'h0000_000F);
    wr("R4 nor", 10, 10, 32'hEDCB_A987);
    wr("R3 write r0", 11, 0, 32'h0000_000C);
    wr("R3 read r0", 12, 11, 32'h0000_0005);
  endtask

  task automatic t_mem();
    step("R7 sw unaligned", pa(13), 1'b0, 5'd0, 32'h0, 1'b1, 32'h0000_000D, 32'h1234_5678);
    wr("R7 lw unaligned", 14, 12, 32'h1234_5678);
    step("R7 sw", pa(15), 1'b0, 5'd0, 32'h0, 1'b1, 32'h0000_0000, 32'hEDCB_A987);
    wr("R8 lw after sw", 16, 13, 32'hEDCB_A987);
  endtask

  task automatic t_branch();
    quiet("R9 beq taken", 17);
    quiet("R9 bne not taken", 20);
    quiet("R9 bne taken", 21);
    quiet("R9 beq not taken", 23);
  endtask

  task automatic t_jump();
    quiet("R10 j", 24);
    wr("R10 landing", 28, 15, 32'h0040_0000);
    wr("R6 ori", 29, 15, 32'h0040_0080);
    quiet("R11 jr", 30);
    wr("R11 landing andi R6", 32, 14, 32'h0000_F0F0);
  endtask

  task automatic t_tail();
    quiet("R12 unknown opcode", 33);
    quiet("R9 backward branch", 34);
    quiet("R9 self loop", 34);
  endtask

  task automatic t_midreset();
    rst = 1'b1;
    #1;
    chk("R1", "rf_we under reset", 32'(dbg_rf_we), 32'h0);
    chk("R1", "mem_we under reset", 32'(dbg_mem_we), 32'h0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    wr("R1 restart", 0, 1, 32'h1234_0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    t_reset();
    t_alu();
    t_mem();
    t_branch();
    t_jump();
    t_tail();
    t_midreset();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule